// File: doc/BRIEF.md
# Cascadable Word Shift Chain with Strobe Latch

This block is the serial data path of a multi-channel display driver. A parallel input word arrives with each rising edge of a shift line. The word enters a chain of word-wide stages and moves one stage on with every shift. The stage farthest from the input drives a word-wide cascade output. That output can feed the data input of the next device in a daisy chain, so a long string of devices loads from one word-wide bus.

When the whole frame has been shifted in, a rising edge on a strobe line copies every stage of the chain into a bank of holding registers in the same cycle. The holding registers feed the per-channel brightness generators, which sit outside this block. Shift and strobe edges are taken only while a two-pin chip select is active: one pin active low, the other active high. The shift line and the strobe are sampled by a single fast system clock and edge-detected inside the block. Reset is synchronous and active high.

Top module: `dchain_top`

## Requirements
- R1: While `rst` is high at a clock edge, every chain stage, `dout_o` and every channel of `lat_o` become zero. All channels stay zero until the first accepted strobe.
- R2: A shift is accepted on the first clock edge at which `sclk_i` is seen high after being seen low, with the chip selected. That edge captures `din_i` into the input stage. Holding `sclk_i` high for more clock cycles causes no further shifts.
- R3: The chain holds `DEPTH` words of `WIDTH` bits. The word accepted at the n-th shift is on `dout_o` from the (n+DEPTH-1)-th shift until the (n+DEPTH)-th shift.
- R4: After `DEPTH` shifts and a strobe, channel k (k = 1 .. DEPTH) holds the k-th of those words, counting from the earliest. Channel k occupies bits `[(k-1)*WIDTH +: WIDTH]` of `lat_o`. Bit `WIDTH-1` of `din_i` is the word MSB and stays bit `WIDTH-1` of the channel.
- R5: An accepted rising strobe edge (`stb_i` seen high after being seen low) copies all `DEPTH` stages into their channels at the same clock edge.
- R6: The chip is selected only when `ce_n_i` is 0 and `ce_i` is 1. In the other three combinations, shift and strobe edges are ignored. The chain, `dout_o` and `lat_o` then keep their values.
- R7: `lat_o` changes only on an accepted strobe edge. Shifts in between leave it unchanged, and holding `stb_i` high does not re-copy.
- R8: If accepted shift and strobe edges fall on the same clock edge, the channels receive the chain contents from before that shift.
- R9: `dout_o` and `lat_o` are registered. They change at the clock edge that accepts the shift or strobe and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Shift line; each rising edge moves the chain one stage |
| stb_i | input | 1 | Strobe line; a rising edge copies the chain to the channels |
| ce_n_i | input | 1 | Chip select, active low |
| ce_i | input | 1 | Chip select, active high |
| din_i | input | WIDTH | Word shifted into the input stage |
| dout_o | output | WIDTH | Last chain stage, for the next device's input |
| lat_o | output | DEPTH*WIDTH | Holding registers; channel k at bits [(k-1)*WIDTH +: WIDTH] |

## Verification
The bench builds the block with `WIDTH` = 4 and `DEPTH` = 6. With these values a full load takes six shifts, and every one of the sixteen word codes can be pushed through the cascade output in a short sweep. The small depth also lets the bench check every channel after each strobe against an arithmetic model. It covers all three deselected pin combinations, held-high shift and strobe lines, and a shift and strobe that land on the same clock edge.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  // Chain stage that feeds channel k (0-based) after a full load:
  // the earliest word travels farthest, so channel 0 reads the last stage.
  function automatic int stage_of_chan(input int chan, input int depth);
    return depth - 1 - chan;
  endfunction

  // Selected when the active-low pin is low and the active-high pin is high.
  function automatic logic chip_selected(input logic sel_n, input logic sel);
    return (!sel_n) && sel;
  endfunction

endpackage

// File: rtl/dchain_edge.sv
module dchain_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic en_i,
  output logic fire_o
);

  logic seen_q;

  // Reset to 1 so a line already high after reset is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b1;
    else     seen_q <= sig_i;
  end

  assign fire_o = sig_i && !seen_q && en_i;

  // R2: one rising edge yields at most one pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o)
    else $error("edge fired on consecutive cycles");

endmodule

// File: rtl/dchain_shift.sv
module dchain_shift #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_i,
  input  logic [WIDTH-1:0]         din_i,
  output logic [DEPTH*WIDTH-1:0]   stages_o,
  output logic [WIDTH-1:0]         dout_o
);

  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] stg_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stg_q[s] <= '0;
    end else if (shift_i) begin
      stg_q[0] <= din_i;
      for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign stages_o[g*WIDTH +: WIDTH] = stg_q[g];
  end

  assign dout_o = stg_q[LAST];

  // R2: accepted shift captures the input word into the head stage
  p_head_capture_r2: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> stg_q[0] == $past(din_i))
    else $error("head stage missed input word");

  // R6: no shift, cascade output holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(dout_o))
    else $error("cascade output moved without a shift");

  if (DEPTH > 1) begin : g_adv
    // R3: the output stage takes its neighbour on each shift
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
      shift_i |=> dout_o == $past(stg_q[LAST-1]))
      else $error("chain did not advance by one stage");
  end

endmodule

// File: rtl/dchain_hold.sv
module dchain_hold #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [DEPTH*WIDTH-1:0] stages_i,
  output logic [DEPTH*WIDTH-1:0] lat_o
);
  import dchain_pkg::*;

  for (genvar k = 0; k < DEPTH; k++) begin : g_chan
    localparam int SRC = stage_of_chan(k, DEPTH);
    logic [WIDTH-1:0] ch_q;

    always_ff @(posedge clk) begin
      if (rst)         ch_q <= '0;
      else if (load_i) ch_q <= stages_i[SRC*WIDTH +: WIDTH];
    end

    assign lat_o[k*WIDTH +: WIDTH] = ch_q;
  end

  // R5 / R4: channel 1 receives the stage nearest the output
  p_copy_first_r5: assert property (@(posedge clk) disable iff (rst)
    load_i |=> lat_o[WIDTH-1:0] == $past(stages_i[(DEPTH-1)*WIDTH +: WIDTH]))
    else $error("channel 1 did not take the last stage");

  // R7: channels keep their values between strobes
  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(lat_o))
    else $error("channels changed without a strobe");

endmodule

// File: rtl/dchain_top.sv
module dchain_top #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk_i,
  input  logic                   stb_i,
  input  logic                   ce_n_i,
  input  logic                   ce_i,
  input  logic [WIDTH-1:0]       din_i,
  output logic [WIDTH-1:0]       dout_o,
  output logic [DEPTH*WIDTH-1:0] lat_o
);
  import dchain_pkg::*;

  logic                   sel;
  logic                   shift_go;
  logic                   latch_go;
  logic [DEPTH*WIDTH-1:0] stages;

  assign sel = chip_selected(ce_n_i, ce_i);

  dchain_edge u_shift_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sclk_i),
    .en_i   (sel),
    .fire_o (shift_go)
  );

  dchain_edge u_strobe_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (stb_i),
    .en_i   (sel),
    .fire_o (latch_go)
  );

  dchain_shift #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_i  (shift_go),
    .din_i    (din_i),
    .stages_o (stages),
    .dout_o   (dout_o)
  );

  dchain_hold #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load_i   (latch_go),
    .stages_i (stages),
    .lat_o    (lat_o)
  );

  // R6: deselected, both the cascade output and the channels hold
  p_deselect_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ce_n_i || !ce_i) |=> ($stable(dout_o) && $stable(lat_o)))
    else $error("state changed while deselected");

endmodule

// File: tb/dchain_top_tb.sv
module dchain_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int D = 6;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, stb = 1'b0, ce_n = 1'b0, ce = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic [D*W-1:0] lat;

  logic [W-1:0] mdl [D];
  logic [W-1:0] mhd [D];
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_top #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .stb_i(stb),
    .ce_n_i(ce_n), .ce_i(ce), .din_i(din), .dout_o(dout), .lat_o(lat)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, int'(dout), int'(mdl[D-1]));
    for (int k = 0; k < D; k++) chk(req, int'(lat[k*W +: W]), int'(mhd[k]));
  endtask

  function automatic logic sel_on();
    return !ce_n && ce;
  endfunction

  task automatic mdl_shift(input logic [W-1:0] w);
    for (int s = D-1; s > 0; s--) mdl[s] = mdl[s-1];
    mdl[0] = w;
  endtask

  task automatic mdl_latch();
    for (int k = 0; k < D; k++) mhd[k] = mdl[D-1-k];
  endtask

  task automatic do_shift(input logic [W-1:0] w);
    @(negedge clk); sclk = 1'b1; din = w;
    @(negedge clk); sclk = 1'b0;
    if (sel_on()) mdl_shift(w);
  endtask

  task automatic do_strobe();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    if (sel_on()) mdl_latch();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < D; s++) begin mdl[s] = '0; mhd[s] = '0; end
    din = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1 reset state");

    // R3 / R4 / R5: one full load then strobe
    for (int i = 0; i < D; i++) begin
      do_shift(W'((i * 5 + 3) & 15));
      chk("R3 cascade during load", int'(dout), int'(mdl[D-1]));
    end
    chk_out("R7 channels before strobe");
    do_strobe();
    for (int k = 0; k < D; k++)
      chk("R4 channel order", int'(lat[k*W +: W]), (k * 5 + 3) & 15);

    // R3: sweep every code twice through the cascade output
    for (int i = 0; i < 32; i++) begin
      do_shift(W'((i * 7 + 1) & 15));
      chk("R3 cascade sweep", int'(dout), int'(mdl[D-1]));
      if (i >= D-1) chk("R3 delay", int'(dout), ((i - (D-1)) * 7 + 1) & 15);
    end
    chk_out("R7 channels unchanged by shifts");
    do_strobe();
    chk_out("R5 copy after sweep");

    // R2: shift line held high gives a single shift
    @(negedge clk); sclk = 1'b1; din = 4'hA;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    mdl_shift(4'hA);
    do_shift(4'h5);
    chk_out("R2 held shift line");

    // R7: strobe held high copies once
    @(negedge clk); stb = 1'b1;
    @(negedge clk); mdl_latch();
    do_shift(4'h9);
    chk_out("R7 held strobe");
    @(negedge clk); stb = 1'b0;

    // R9: nothing moves before the accepting edge
    @(negedge clk); sclk = 1'b1; din = 4'h3;
    #(CLK_PERIOD/4);
    chk("R9 before edge", int'(dout), int'(mdl[D-1]));
    @(negedge clk); sclk = 1'b0; mdl_shift(4'h3);
    chk("R9 after edge", int'(dout), int'(mdl[D-1]));

    // R6: all three deselected combinations
    for (int c = 0; c < 3; c++) begin
      ce_n = (c != 1); ce = (c == 2) ? 1'b0 : (c == 0);
      for (int i = 0; i < 3; i++) do_shift(W'(c * 3 + i));
      do_strobe();
      chk_out("R6 deselected");
    end
    ce_n = 1'b0; ce = 1'b1;

    // R8: shift and strobe on the same edge
    @(negedge clk); sclk = 1'b1; stb = 1'b1; din = 4'hE;
    @(negedge clk); sclk = 1'b0; stb = 1'b0;
    mdl_latch(); mdl_shift(4'hE);
    chk_out("R8 simultaneous edges");

    // R1: reset in mid operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int s = 0; s < D; s++) begin mdl[s] = '0; mhd[s] = '0; end
    chk_out("R1 mid-run reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule